// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

The block turns a 16-bit logical address into a physical address by paging. The upper five address bits select one of 32 pages and the lower eleven bits are a byte offset that passes through untouched. A small fully associative translation cache is searched in parallel for the page. On a hit, the cached frame number is joined to the offset. On a miss, a 32-entry page table held in the block is read. A valid result is installed in the cache, replacing an older entry when the cache is full, and the response then follows.

Each page-table entry carries a valid bit, a frame number and a write-permission bit. Every access is checked against that bit, so a write to a read-only page returns a protection fault. A request for a page with no valid entry returns a page fault and leaves the cache unchanged. Software fills the table through a single write port. Two free-running counters of cache hits and misses let the hit ratio be observed.

Requests use a valid/ready handshake with a read/write flag. Responses come back as a one-cycle pulse that carries the physical address and a status code.

Top module: `vpage_translator`

## Requirements
- R1: The page number is `req_addr[15:11]` and the offset is `req_addr[10:0]`. On a successful response, `rsp_paddr[10:0]` equals the offset and `rsp_paddr[16:11]` equals the frame number from the page table.
- R2: A request that hits the cache is answered by a one-cycle `rsp_valid` pulse in the cycle right after it is accepted, and `hit_count` grows by one.
- R3: A request that misses is answered two cycles later than a hit, in the third cycle after acceptance. `req_ready` stays low until the response, and `miss_count` grows by one. When the table entry is valid, it is installed so that the next request to that page hits.
- R4: The cache has 4 entries. A fill takes the lowest-numbered empty entry. When all entries are in use, a fill overwrites the entry named by a round-robin pointer. That pointer starts at entry 0 and advances by one, wrapping, only on such an overwrite.
- R5: Status code 2'b00 means success. Code 2'b01 means a write to a page whose permission bit is 0 (read-only). Reads of any valid page, and writes to pages whose permission bit is 1, succeed. A protection fault still installs the translation, and `rsp_paddr` is zero on any fault.
- R6: A request for a page whose table entry is invalid returns status 2'b10, even when the request is a write, and installs nothing, so a repeat request misses again. Status 2'b11 never occurs.
- R7: A page-table write removes any cached copy of that page. A lookup of the same page in the same cycle is treated as a miss that uses the new entry. A write that arrives in the cycle the table is being read for a miss is forwarded into that miss. A write during the final miss cycle blocks the install.
- R8: After reset, `req_ready` is 1, `rsp_valid` is 0, both counters are 0, the cache is empty and every page-table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 16 | Logical address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 17 | Physical address, zero on a fault |
| rsp_status | output | 2 | 00 ok, 01 protection fault, 10 page fault |
| pt_wr_en | input | 1 | Write one page-table entry |
| pt_wr_page | input | 5 | Page whose entry is written |
| pt_wr_frame | input | 6 | Frame number for that page |
| pt_wr_valid | input | 1 | Entry valid bit |
| pt_wr_rw | input | 1 | 1 = writable, 0 = read-only |
| hit_count | output | 16 | Number of cache hits since reset |
| miss_count | output | 16 | Number of cache misses since reset |

## Verification
A page-table write and a translation of the same page can land in one cycle. This happens either at the cache lookup or while a miss is reading the table. The bench provokes the first case by raising the table write together with a request for a cached page, and the second by raising the write one cycle after a missing request is accepted. It judges each case from the latency of the response and from the frame returned: the first must take the miss path and return the new frame, and the second must return the forwarded frame. A follow-up request to the same page must then hit with the new frame.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        XS_OK    = 2'b00,
        XS_PROT  = 2'b01,
        XS_PGFLT = 2'b10
    } xlat_status_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_READ = 2'b01,
        ST_FILL = 2'b10
    } xlat_state_e;

    function automatic xlat_status_e judge_access(input logic ent_valid,
                                                  input logic ent_rw,
                                                  input logic is_write);
        if (!ent_valid)
            return XS_PGFLT;
        else if (is_write && !ent_rw)
            return XS_PROT;
        else
            return XS_OK;
    endfunction

endpackage

// File: rtl/xlat_ptable.sv
module xlat_ptable #(
    parameter int PAGE_W  = 5,
    parameter int FRAME_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PAGE_W-1:0]  wr_page,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_valid,
    input  logic               wr_rw,
    input  logic [PAGE_W-1:0]  rd_page,
    output logic [FRAME_W-1:0] rd_frame,
    output logic               rd_valid,
    output logic               rd_rw
);
    localparam int DEPTH = 1 << PAGE_W;

    typedef struct packed {
        logic               valid;
        logic               rw;
        logic [FRAME_W-1:0] frame;
    } pte_t;

    pte_t [DEPTH-1:0] tbl_d, tbl_q;
    pte_t             rd_ent;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en)
            tbl_d[wr_page] = '{valid: wr_valid, rw: wr_rw, frame: wr_frame};
        // a write in the reading cycle is forwarded to the reader
        if (wr_en && (wr_page == rd_page))
            rd_ent = '{valid: wr_valid, rw: wr_rw, frame: wr_frame};
        else
            rd_ent = tbl_q[rd_page];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tbl_q <= '0;
        else
            tbl_q <= tbl_d;
    end

    assign rd_frame = rd_ent.frame;
    assign rd_valid = rd_ent.valid;
    assign rd_rw    = rd_ent.rw;

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
    parameter int PAGE_W  = 5,
    parameter int FRAME_W = 6,
    parameter int ENTRIES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PAGE_W-1:0]  lk_page,
    output logic               lk_hit,
    output logic [FRAME_W-1:0] lk_frame,
    output logic               lk_rw,
    input  logic               inv_en,
    input  logic [PAGE_W-1:0]  inv_page,
    input  logic               fill_en,
    input  logic [PAGE_W-1:0]  fill_page,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic               fill_rw
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic               valid;
        logic [PAGE_W-1:0]  page;
        logic [FRAME_W-1:0] frame;
        logic               rw;
    } tlb_ent_t;

    typedef struct packed {
        tlb_ent_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]       ptr;
    } tlb_st_t;

    tlb_st_t              st_d, st_q;
    logic [ENTRIES-1:0]   match;
    logic                 any_match;
    logic [FRAME_W-1:0]   match_frame;
    logic                 match_rw;
    logic                 have_free;
    logic [IDX_W-1:0]     free_idx;
    logic [IDX_W-1:0]     victim;

    // parallel key compare, one comparator per entry
    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
        assign match[gi] = st_q.ent[gi].valid && (st_q.ent[gi].page == lk_page);
    end

    always_comb begin
        any_match   = 1'b0;
        match_frame = '0;
        match_rw    = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                any_match   = 1'b1;
                match_frame = match_frame | st_q.ent[i].frame;
                match_rw    = match_rw | st_q.ent[i].rw;
            end
        end
    end

    // a table write to the looked-up page suppresses the hit
    assign lk_hit   = any_match && !(inv_en && (inv_page == lk_page));
    assign lk_frame = match_frame;
    assign lk_rw    = match_rw;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!st_q.ent[i].valid) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
        victim = have_free ? free_idx : st_q.ptr;
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (inv_en && st_q.ent[i].valid && (st_q.ent[i].page == inv_page))
                st_d.ent[i].valid = 1'b0;
        end
        if (fill_en) begin
            st_d.ent[victim] = '{valid: 1'b1, page: fill_page,
                                 frame: fill_frame, rw: fill_rw};
            if (!have_free)
                st_d.ptr = (st_q.ptr == LAST_IDX) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/vpage_translator.sv
module vpage_translator
    import xlat_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 5,
    parameter int FRAME_W     = 6,
    parameter int TLB_ENTRIES = 4,
    parameter int CNT_W       = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_write,
    output logic                       rsp_valid,
    output logic [FRAME_W+ADDR_W-PAGE_W-1:0] rsp_paddr,
    output logic [1:0]                 rsp_status,
    input  logic                       pt_wr_en,
    input  logic [PAGE_W-1:0]          pt_wr_page,
    input  logic [FRAME_W-1:0]         pt_wr_frame,
    input  logic                       pt_wr_valid,
    input  logic                       pt_wr_rw,
    output logic [CNT_W-1:0]           hit_count,
    output logic [CNT_W-1:0]           miss_count
);
    localparam int OFF_W   = ADDR_W - PAGE_W;
    localparam int PADDR_W = FRAME_W + OFF_W;

    typedef struct packed {
        xlat_state_e        state;
        logic [PAGE_W-1:0]  page;
        logic [OFF_W-1:0]   off;
        logic               write;
        logic               pte_valid;
        logic               pte_rw;
        logic [FRAME_W-1:0] pte_frame;
        logic               rsp_valid;
        logic [PADDR_W-1:0] rsp_paddr;
        xlat_status_e       rsp_status;
        logic [CNT_W-1:0]   hit_cnt;
        logic [CNT_W-1:0]   miss_cnt;
    } xl_st_t;

    xl_st_t st_d, st_q;

    logic [PAGE_W-1:0]  req_page;
    logic [OFF_W-1:0]   req_off;
    logic               tlb_hit;
    logic [FRAME_W-1:0] tlb_frame;
    logic               tlb_rw;
    logic               fill_en;
    logic [FRAME_W-1:0] pt_frame;
    logic               pt_valid;
    logic               pt_rw;
    xlat_status_e       verdict;

    assign req_page = req_addr[ADDR_W-1:OFF_W];
    assign req_off  = req_addr[OFF_W-1:0];

    xlat_tlb #(
        .PAGE_W  (PAGE_W),
        .FRAME_W (FRAME_W),
        .ENTRIES (TLB_ENTRIES)
    ) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_page    (req_page),
        .lk_hit     (tlb_hit),
        .lk_frame   (tlb_frame),
        .lk_rw      (tlb_rw),
        .inv_en     (pt_wr_en),
        .inv_page   (pt_wr_page),
        .fill_en    (fill_en),
        .fill_page  (st_q.page),
        .fill_frame (st_q.pte_frame),
        .fill_rw    (st_q.pte_rw)
    );

    xlat_ptable #(
        .PAGE_W  (PAGE_W),
        .FRAME_W (FRAME_W)
    ) u_ptable (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pt_wr_en),
        .wr_page  (pt_wr_page),
        .wr_frame (pt_wr_frame),
        .wr_valid (pt_wr_valid),
        .wr_rw    (pt_wr_rw),
        .rd_page  (st_q.page),
        .rd_frame (pt_frame),
        .rd_valid (pt_valid),
        .rd_rw    (pt_rw)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        fill_en        = 1'b0;
        verdict        = XS_OK;
        case (st_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (tlb_hit) begin
                        verdict         = judge_access(1'b1, tlb_rw, req_write);
                        st_d.rsp_valid  = 1'b1;
                        st_d.rsp_status = verdict;
                        st_d.rsp_paddr  = (verdict == XS_OK) ? {tlb_frame, req_off} : '0;
                        st_d.hit_cnt    = st_q.hit_cnt + 1'b1;
                    end else begin
                        st_d.state    = ST_READ;
                        st_d.page     = req_page;
                        st_d.off      = req_off;
                        st_d.write    = req_write;
                        st_d.miss_cnt = st_q.miss_cnt + 1'b1;
                    end
                end
            end
            ST_READ: begin
                st_d.pte_valid = pt_valid;
                st_d.pte_rw    = pt_rw;
                st_d.pte_frame = pt_frame;
                st_d.state     = ST_FILL;
            end
            ST_FILL: begin
                verdict         = judge_access(st_q.pte_valid, st_q.pte_rw, st_q.write);
                st_d.rsp_valid  = 1'b1;
                st_d.rsp_status = verdict;
                st_d.rsp_paddr  = (verdict == XS_OK) ? {st_q.pte_frame, st_q.off} : '0;
                fill_en         = st_q.pte_valid &&
                                  !(pt_wr_en && (pt_wr_page == st_q.page));
                st_d.state      = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.state      <= ST_IDLE;
            st_q.rsp_status <= XS_OK;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = (st_q.state == ST_IDLE);
    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_paddr  = st_q.rsp_paddr;
    assign rsp_status = st_q.rsp_status;
    assign hit_count  = st_q.hit_cnt;
    assign miss_count = st_q.miss_cnt;

endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
    parameter int OFF_W   = 11,
    parameter int PADDR_W = 17,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [OFF_W-1:0]   req_off,
    input logic               rsp_valid,
    input logic [PADDR_W-1:0] rsp_paddr,
    input logic [1:0]         rsp_status,
    input logic [CNT_W-1:0]   hit_count,
    input logic [CNT_W-1:0]   miss_count
);
    logic [OFF_W-1:0] off_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            off_seen <= '0;
        else if (req_valid && req_ready)
            off_seen <= req_off;
    end

    // R2
    hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid == (hit_count != $past(hit_count))));

    // R3
    miss_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count != $past(miss_count)) |-> (!rsp_valid ##1 !rsp_valid ##1 rsp_valid));

    // R3
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count != $past(miss_count)) |-> (!req_ready ##1 !req_ready));

    // R5
    fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_status != 2'b00)) |-> (rsp_paddr == '0));

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_status == 2'b00)) |-> (rsp_paddr[OFF_W-1:0] == off_seen));

    // R6
    status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'b11));

endmodule

bind vpage_translator xlat_chk #(
    .OFF_W   (OFF_W),
    .PADDR_W (PADDR_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_off    (req_addr[OFF_W-1:0]),
    .rsp_valid  (rsp_valid),
    .rsp_paddr  (rsp_paddr),
    .rsp_status (rsp_status),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/vpage_translator_bench.sv
`timescale 1ns/1ps
module vpage_translator_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [16:0] rsp_paddr;
    logic [1:0]  rsp_status;
    logic        pt_wr_en = 1'b0;
    logic [4:0]  pt_wr_page = '0;
    logic [5:0]  pt_wr_frame = '0;
    logic        pt_wr_valid = 1'b0;
    logic        pt_wr_rw = 1'b0;
    logic [15:0] hit_count;
    logic [15:0] miss_count;

    always #4 clk = ~clk;

    vpage_translator u_vpage_translator (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_status(rsp_status),
        .pt_wr_en(pt_wr_en), .pt_wr_page(pt_wr_page), .pt_wr_frame(pt_wr_frame),
        .pt_wr_valid(pt_wr_valid), .pt_wr_rw(pt_wr_rw),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int n_run  = 0;
    int n_fail = 0;
    int exp_hits = 0;
    int exp_miss = 0;

    logic       m_valid [32];
    logic       m_rw    [32];
    logic [5:0] m_frame [32];

    // staged side write for race cases
    logic [4:0] sp_page;
    logic [5:0] sp_frame;
    logic       sp_valid;
    logic       sp_rw;

    typedef struct packed {
        logic [4:0]  pg;
        logic [10:0] off;
        logic        wr;
        logic        hit;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  11'h005, 1'b0, 1'b0, 4'd3},
        '{5'd0,  11'h7FF, 1'b1, 1'b1, 4'd5},
        '{5'd1,  11'h123, 1'b1, 1'b0, 4'd5},
        '{5'd1,  11'h040, 1'b0, 1'b1, 4'd2},
        '{5'd2,  11'h3A0, 1'b0, 1'b0, 4'd3},
        '{5'd3,  11'h001, 1'b0, 1'b0, 4'd3},
        '{5'd4,  11'h555, 1'b0, 1'b0, 4'd4},
        '{5'd1,  11'h2AA, 1'b0, 1'b1, 4'd4},
        '{5'd0,  11'h000, 1'b0, 1'b0, 4'd4},
        '{5'd1,  11'h010, 1'b0, 1'b0, 4'd4},
        '{5'd3,  11'h011, 1'b0, 1'b1, 4'd4},
        '{5'd2,  11'h012, 1'b0, 1'b0, 4'd4},
        '{5'd3,  11'h013, 1'b1, 1'b0, 4'd4},
        '{5'd4,  11'h014, 1'b1, 1'b0, 4'd5},
        '{5'd4,  11'h015, 1'b0, 1'b1, 4'd5},
        '{5'd20, 11'h100, 1'b0, 1'b0, 4'd6},
        '{5'd20, 11'h101, 1'b1, 1'b0, 4'd6},
        '{5'd20, 11'h102, 1'b0, 1'b0, 4'd6}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic pt_load(input logic [4:0] pg, input logic [5:0] fr,
                           input logic vld, input logic rw);
        @(negedge clk);
        pt_wr_en = 1'b1; pt_wr_page = pg; pt_wr_frame = fr;
        pt_wr_valid = vld; pt_wr_rw = rw;
        m_valid[pg] = vld; m_rw[pg] = rw; m_frame[pg] = fr;
        @(negedge clk);
        pt_wr_en = 1'b0;
    endtask

    task automatic drive_side();
        pt_wr_en = 1'b1; pt_wr_page = sp_page; pt_wr_frame = sp_frame;
        pt_wr_valid = sp_valid; pt_wr_rw = sp_rw;
    endtask

    // mode 0: plain; 1: table write in the request cycle; 2: table write in the read cycle
    task automatic run(input logic [4:0] pg, input logic [10:0] off, input logic wr,
                       input logic exp_hit, input string tag, input int mode);
        int lat;
        logic [1:0]  e_st;
        logic [16:0] e_pa;
        if (mode != 0) begin
            m_valid[sp_page] = sp_valid; m_rw[sp_page] = sp_rw; m_frame[sp_page] = sp_frame;
        end
        e_st = !m_valid[pg] ? 2'b10 : ((wr && !m_rw[pg]) ? 2'b01 : 2'b00);
        e_pa = (e_st == 2'b00) ? {m_frame[pg], off} : 17'd0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = {pg, off}; req_write = wr;
        if (mode == 1) drive_side();
        @(negedge clk);
        req_valid = 1'b0; pt_wr_en = 1'b0; lat = 1;
        if (!exp_hit)
            chk(req_ready == 1'b0, "R3", "ready low during miss", req_ready, 0);
        if (mode == 2) drive_side();
        while (!rsp_valid && lat < 8) begin
            @(negedge clk);
            pt_wr_en = 1'b0;
            lat++;
        end
        if (exp_hit) exp_hits++; else exp_miss++;
        chk(lat == (exp_hit ? 1 : 3), exp_hit ? "R2" : "R3", "latency", lat, exp_hit ? 1 : 3);
        chk(rsp_status == e_st, tag, "status", rsp_status, e_st);
        chk(rsp_paddr == e_pa, "R1", "paddr", rsp_paddr, e_pa);
        chk(hit_count == 16'(exp_hits), "R2", "hit count", hit_count, exp_hits);
        chk(miss_count == 16'(exp_miss), "R3", "miss count", miss_count, exp_miss);
    endtask

    bit finished = 1'b0;

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_valid[i] = 1'b0; m_rw[i] = 1'b0; m_frame[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(req_ready == 1'b1, "R8", "ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R8", "rsp_valid after reset", rsp_valid, 0);
        chk(hit_count == 16'd0, "R8", "hit count after reset", hit_count, 0);
        chk(miss_count == 16'd0, "R8", "miss count after reset", miss_count, 0);
        // R8 table starts invalid: page fault before any load
        run(5'd7, 11'h0AB, 1'b0, 1'b0, "R8", 0);

        for (int p = 0; p < 10; p++)
            pt_load(5'(p), 6'(p * 3 + 1), 1'b1, p[0]);

        for (int v = 0; v < NV; v++)
            run(VECS[v].pg, VECS[v].off, VECS[v].wr, VECS[v].hit, tag_name(VECS[v].tag), 0);

        // R7 table write to a cached page in the lookup cycle forces a miss
        sp_page = 5'd3; sp_frame = 6'd50; sp_valid = 1'b1; sp_rw = 1'b1;
        run(5'd3, 11'h222, 1'b1, 1'b0, "R7", 1);
        run(5'd3, 11'h223, 1'b0, 1'b1, "R7", 0);

        // R7 write during the table-read cycle is forwarded
        sp_page = 5'd5; sp_frame = 6'd33; sp_valid = 1'b1; sp_rw = 1'b0;
        run(5'd5, 11'h0F0, 1'b0, 1'b0, "R7", 2);
        run(5'd5, 11'h0F1, 1'b1, 1'b1, "R7", 0);

        // R7 invalidating a cached page drops the cached copy
        pt_load(5'd2, 6'd9, 1'b0, 1'b0);
        run(5'd2, 11'h030, 1'b0, 1'b0, "R7", 0);

        // R7 unrelated table write does not disturb a hit
        sp_page = 5'd9; sp_frame = 6'd60; sp_valid = 1'b1; sp_rw = 1'b1;
        run(5'd4, 11'h031, 1'b0, 1'b1, "R7", 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule